// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds a small set of machine-check error banks. Each bank has four 64-bit registers: control, status, address and auxiliary (misc). Three global registers sit beside them: capability, control and status. An error source hands over one error per one-cycle strobe on the injection port. Each error carries a bank number, a bank status word, a global status word, an address and an auxiliary value.

On each error the logger does one of five things. It ignores the error, records it, overwrites an older entry, marks an overflow only, or gives up. Giving up happens when an uncorrected error cannot be delivered, and the logger then asks for a system reset. When an uncorrected error is recorded, the logger raises a machine-check interrupt.

Software reads and writes every register through a plain word-addressed port. Reads are combinational. Writes take effect at the clock edge.

Top module: `mce_bank_logger`

## Requirements
- R1: After reset the global control and every bank control read all ones. The capability register reads `CAP_INIT` (default 0x104: four banks, control-present flag set). All status, address and misc registers read zero, and both pulse outputs are low.
- R2: The bank count is bits 7:0 of the capability register. An error naming a bank at or above that count, or at or above `NBANK`, changes no register and raises no pulse.
- R3: Status bit 63 is the valid bit. An error with bit 63 clear changes no register and raises no pulse.
- R4: Status bit 61 marks an uncorrected error, and capability bit 8 is the control-present flag. An uncorrected error is dropped without effect when the flag is set and the global control is not all ones.
- R5: An uncorrected error is dropped without effect when its bank's control register is not all ones.
- R6: An uncorrected error that passes R2 to R5 is not delivered in two cases: global status bit 2 (check in progress) is already set, or `mc_enable` is low. In either case `reset_req` pulses for exactly one cycle, in the cycle after the strobe, and no register changes.
- R7: A delivered uncorrected error writes four registers: the bank address, the bank misc, the global status (from the error's global word) and the bank status. The bank status is set to the error's status, with bit 62 (overflow) forced high if the bank already held a valid entry. `mc_irq` pulses for one cycle, in the cycle after the strobe.
- R8: A corrected error (bit 61 clear) is handled when the bank is empty or holds a corrected entry. It overwrites the bank's status, address and misc, with bit 62 forced high if the bank was valid. It raises no pulse.
- R9: A corrected error that meets a valid uncorrected entry only sets bit 62 of that entry's status. Every other register keeps its value.
- R10: Register map, by word address: 0 capability, 1 global control, 2 global status. The registers of bank b sit at 4+4b (control), 5+4b (status), 6+4b (address) and 7+4b (misc). Writes to any of these read back, and other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_enable | input | 1 | Machine-check delivery enabled by the processor |
| inj_valid | input | 1 | One-cycle strobe presenting an error |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Bank status word of the error |
| inj_gstatus | input | 64 | Global status word of the error |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Auxiliary error information |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The assertions assume two things about the error fields. First, they are known whenever the strobe is high. Second, the strobe is never high in two adjacent cycles, so each pulse can be tied to the single strobe one cycle before it. The stimulus meets both assumptions: every error is sent through one task that raises the strobe for one cycle and then drops it. The stimulus also never writes a register in the same cycle as an error, so the relative priority of those two paths is never exercised.

// File: rtl/mce_bank_logger.sv
module mce_bank_logger #(
  parameter int NBANK = 4,
  parameter int AW = 6,
  parameter logic [63:0] CAP_INIT = 64'h104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_enable,
  input  logic          inj_valid,
  input  logic [7:0]    inj_bank,
  input  logic [63:0]   inj_status,
  input  logic [63:0]   inj_gstatus,
  input  logic [63:0]   inj_addr,
  input  logic [63:0]   inj_misc,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          mc_irq,
  output logic          reset_req
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int VAL = 63, OVF = 62, UNC = 61, INPROG = 2, CTLP = 8;

  logic [63:0] cap, gctl, gstat;
  logic [63:0] bctl [NBANK];
  logic [63:0] bst  [NBANK];
  logic [63:0] badr [NBANK];
  logic [63:0] bmsc [NBANK];

  logic [BW-1:0] isel;
  logic in_rng, unc, take, blocked, old_val, old_unc;

  assign isel    = inj_bank[BW-1:0];
  assign in_rng  = (inj_bank < cap[7:0]) && (32'(inj_bank) < NBANK);
  assign unc     = inj_status[UNC];
  assign old_val = bst[isel][VAL];
  assign old_unc = bst[isel][UNC];
  assign take    = inj_valid && inj_status[VAL] && in_rng &&
                   !(unc && cap[CTLP] && gctl != '1) &&
                   !(unc && bctl[isel] != '1);
  assign blocked = gstat[INPROG] || !mc_enable;

  logic [AW-1:0] off;
  logic [AW-3:0] wbank;
  assign off   = reg_addr - AW'(4);
  assign wbank = off[AW-1:2];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata = cap;
    else if (reg_addr == AW'(1)) reg_rdata = gctl;
    else if (reg_addr == AW'(2)) reg_rdata = gstat;
    else if (reg_addr >= AW'(4) && 32'(wbank) < NBANK) begin
      case (off[1:0])
        2'd0: reg_rdata = bctl[BW'(wbank)];
        2'd1: reg_rdata = bst[BW'(wbank)];
        2'd2: reg_rdata = badr[BW'(wbank)];
        default: reg_rdata = bmsc[BW'(wbank)];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= CAP_INIT;
      gctl <= '1;
      gstat <= '0;
      mc_irq <= 1'b0;
      reset_req <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        bctl[b] <= '1;
        bst[b]  <= '0;
        badr[b] <= '0;
        bmsc[b] <= '0;
      end
    end else begin
      mc_irq <= 1'b0;
      reset_req <= 1'b0;
      if (reg_we) begin
        if (reg_addr == AW'(0)) cap <= reg_wdata;
        else if (reg_addr == AW'(1)) gctl <= reg_wdata;
        else if (reg_addr == AW'(2)) gstat <= reg_wdata;
        else if (reg_addr >= AW'(4) && 32'(wbank) < NBANK) begin
          case (off[1:0])
            2'd0: bctl[BW'(wbank)] <= reg_wdata;
            2'd1: bst[BW'(wbank)]  <= reg_wdata;
            2'd2: badr[BW'(wbank)] <= reg_wdata;
            default: bmsc[BW'(wbank)] <= reg_wdata;
          endcase
        end
      end
      if (take) begin
        if (unc) begin
          if (blocked) reset_req <= 1'b1;
          else begin
            badr[isel] <= inj_addr;
            bmsc[isel] <= inj_misc;
            gstat      <= inj_gstatus;
            bst[isel]  <= inj_status | (64'(old_val) << OVF);
            mc_irq     <= 1'b1;
          end
        end else if (!old_val || !old_unc) begin
          badr[isel] <= inj_addr;
          bmsc[isel] <= inj_misc;
          bst[isel]  <= inj_status | (64'(old_val) << OVF);
        end else begin
          bst[isel][OVF] <= 1'b1;
        end
      end
    end
  end
endmodule

module mce_bank_logger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inj_valid,
  input logic [63:0] inj_status,
  input logic        mc_irq,
  input logic        reset_req
);
  // R6
  irq_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mc_irq && reset_req));
  // R7
  irq_after_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && !(inj_status[63] && inj_status[61]) |=> !mc_irq);
  // R6
  rst_after_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && !(inj_status[63] && inj_status[61]) |=> !reset_req);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |=> !mc_irq && !reset_req);
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_irq && !inj_valid |=> !mc_irq);
endmodule

bind mce_bank_logger mce_bank_logger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_status(inj_status),
  .mc_irq(mc_irq), .reset_req(reset_req));

// File: tb/mce_bank_logger_tb.sv
module mce_bank_logger_tb;
  localparam int NB = 4;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] O = 64'h4000_0000_0000_0000;
  localparam logic [63:0] U = 64'h2000_0000_0000_0000;

  logic clk = 0, rst_n = 0, mc_enable = 1, inj_valid = 0, reg_we = 0;
  logic [7:0] inj_bank = 0;
  logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0;
  logic [5:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic mc_irq, reset_req;

  int vectors = 0, errors = 0;
  logic [63:0] m_cap, m_gctl, m_gst;
  logic [63:0] m_ctl [NB], m_st [NB], m_ad [NB], m_ms [NB];

  always #4 clk = ~clk;

  mce_bank_logger u_dut (.clk, .rst_n, .mc_enable, .inj_valid, .inj_bank,
    .inj_status, .inj_gstatus, .inj_addr, .inj_misc, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .mc_irq, .reset_req);

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_rd(int a);
    if (a == 0) return m_cap;
    if (a == 1) return m_gctl;
    if (a == 2) return m_gst;
    if (a >= 4 && (a - 4) / 4 < NB) begin
      case ((a - 4) % 4)
        0: return m_ctl[(a - 4) / 4];
        1: return m_st[(a - 4) / 4];
        2: return m_ad[(a - 4) / 4];
        default: return m_ms[(a - 4) / 4];
      endcase
    end
    return 64'h0;
  endfunction

  task automatic check_all(string tag);
    for (int a = 0; a < 24; a++) begin
      @(negedge clk);
      reg_addr = 6'(a);
      #1 cmp(tag, reg_rdata, model_rd(a));
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 0) m_cap = d;
    else if (a == 1) m_gctl = d;
    else if (a == 2) m_gst = d;
    else if (a >= 4 && (a - 4) / 4 < NB) begin
      case ((a - 4) % 4)
        0: m_ctl[(a - 4) / 4] = d;
        1: m_st[(a - 4) / 4] = d;
        2: m_ad[(a - 4) / 4] = d;
        default: m_ms[(a - 4) / 4] = d;
      endcase
    end
  endtask

  task automatic inject(string tag, int b, logic [63:0] st, logic [63:0] gs,
                        logic [63:0] ad, logic [63:0] ms);
    bit ei = 0, er = 0;
    bit is_unc = st[61];
    if (st[63] && b < int'(m_cap[7:0]) && b < NB) begin
      if (is_unc && ((m_cap[8] && m_gctl != '1) || m_ctl[b] != '1)) begin
      end else if (is_unc) begin
        if (m_gst[2] || !mc_enable) er = 1;
        else begin
          m_st[b] = st | (m_st[b][63] ? O : 64'h0);
          m_ad[b] = ad; m_ms[b] = ms; m_gst = gs; ei = 1;
        end
      end else if (m_st[b][63] && m_st[b][61]) m_st[b] = m_st[b] | O;
      else begin
        m_st[b] = st | (m_st[b][63] ? O : 64'h0);
        m_ad[b] = ad; m_ms[b] = ms;
      end
    end
    @(negedge clk);
    inj_valid = 1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
    inj_addr = ad; inj_misc = ms;
    @(negedge clk);
    inj_valid = 0;
    cmp({tag, " irq"}, {63'h0, mc_irq}, {63'h0, ei});
    cmp({tag, " rst"}, {63'h0, reset_req}, {63'h0, er});
    @(negedge clk);
    cmp({tag, " irq end"}, {63'h0, mc_irq}, 64'h0);
    cmp({tag, " rst end"}, {63'h0, reset_req}, 64'h0);
    check_all(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_cap = 64'h104; m_gctl = '1; m_gst = 0;
    for (int b = 0; b < NB; b++) begin
      m_ctl[b] = '1; m_st[b] = 0; m_ad[b] = 0; m_ms[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 irq", {63'h0, mc_irq}, 64'h0);
    cmp("R1 rst", {63'h0, reset_req}, 64'h0);
    check_all("R1");

    inject("R3", 0, 64'h11, 64'h4, 64'hA0, 64'hB0);
    inject("R2", 4, V | U, 64'h0, 64'hA1, 64'hB1);
    wr(0, 64'h102);
    check_all("R10");
    inject("R2", 2, V, 64'h0, 64'hA2, 64'hB2);
    wr(0, 64'h104);

    inject("R8", 1, V | 64'h11, 64'h0, 64'h1000, 64'h2000);
    inject("R8", 1, V | 64'h22, 64'h0, 64'h1100, 64'h2100);
    inject("R7", 2, V | U | 64'h33, 64'h4, 64'h3000, 64'h4000);
    inject("R9", 2, V | 64'h44, 64'h0, 64'h5000, 64'h6000);
    inject("R6", 3, V | U | 64'h55, 64'h5, 64'h7000, 64'h8000);
    wr(2, 64'h0);
    mc_enable = 0;
    inject("R6", 3, V | U | 64'h56, 64'h1, 64'h7100, 64'h8100);
    mc_enable = 1;
    wr(1, 64'h0);
    inject("R4", 3, V | U | 64'h66, 64'h1, 64'h9000, 64'hA000);
    inject("R8", 3, V | 64'h67, 64'h0, 64'h9100, 64'hA100);
    wr(1, '1);
    wr(4, 64'h0);
    inject("R5", 0, V | U | 64'h77, 64'h1, 64'hB000, 64'hC000);
    inject("R7", 1, V | U | 64'h88, 64'h1, 64'hD000, 64'hE000);
    wr(9, 64'h123);
    check_all("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule